// File: doc/BRIEF.md
# Connection Receive Window Timer

This block decides when the radio receiver of a connected low-energy link listens. It runs one of two window kinds. A reply window follows the local transmitter: it is armed by the end of an outgoing packet and sits around the point 150 us later where the peer's answer should begin. An anchor window is armed by a strobe from the connection scheduler. It is centred on a point a fixed lead time after that strobe, and it is widened on each side by the drift the two sleep clocks can build up since the last good anchor.

Inside either window, a sync pulse from the demodulator (the access address was matched) turns the fixed timeout into a hold. The receiver then stays on until the packet-end pulse, and the transmit-start strobe for the local reply is issued 150 us after that end. If no sync arrives, the window shuts shortly after the latest point at which sync could have been seen, and a missed-event pulse is raised. Consecutive misses stretch later anchor windows. A received packet returns them to the base width.

All timing is counted in pulses of a one-microsecond tick input. The block has no data stream. Every pin is a plain level or single-cycle strobe, so there is no valid/ready handshake and no back-pressure.

Top module: `rxw_timer`

## Requirements
- R1: After reset, rx_enable, tx_start and missed are all low, and the consecutive-miss count m is 0.
- R2: A tx_end strobe in idle arms a reply window. rx_enable rises in the cycle after the 148th tick that follows the strobe (150 us minus 2 us of jitter).
- R3: A sync_found pulse while rx_enable is high keeps rx_enable high past any timeout. rx_enable falls in the cycle after a pkt_end pulse.
- R4: When no sync arrives in a reply window, rx_enable falls and missed is high for exactly one cycle, both after the 192nd tick (150 + 40 preamble and access address + 2). A sync pulse between the 191st and 192nd ticks is still accepted.
- R5: tx_start is a one-cycle pulse in the cycle after the 150th tick following an accepted pkt_end.
- R6: The anchor widening is W = ceil(peer_ppm·E/10^6) + ceil(local_ppm·E/10^6) + 16, where E = interval_us·(m+1). rx_enable rises in the cycle after tick LEAD−W, counted from the anchor strobe. LEAD is the parameter ANCHOR_LEAD_US (default 500).
- R7: When an anchor window gets no sync, rx_enable falls and missed pulses after tick LEAD+40+W.
- R8: Each window closed by timeout adds 1 to m, saturating at 7. An accepted pkt_end sets m to 0.
- R9: W is clamped to LEAD. When W equals LEAD, rx_enable rises in the cycle after the anchor strobe.
- R10: These inputs are ignored: tx_end or anchor while a window is armed, open or held; sync_found before the window opens; and pkt_end outside a held window (no tx_start follows it).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| tx_end | input | 1 | Last bit of the local transmission sent |
| anchor | input | 1 | Arms an anchor window; the nominal start is ANCHOR_LEAD_US ticks later |
| sync_found | input | 1 | Access address matched |
| pkt_end | input | 1 | Last bit of the received packet |
| peer_ppm | input | 10 | Peer sleep-clock accuracy in ppm |
| local_ppm | input | 10 | Local sleep-clock accuracy in ppm |
| interval_us | input | 22 | Time between anchors in microseconds |
| rx_enable | output | 1 | Receiver on |
| tx_start | output | 1 | Start the local transmission |
| missed | output | 1 | One-cycle pulse: the window closed without sync |

## Verification
The hardest state to reach from the ports is a widened anchor window after several misses in a row. The miss count cannot be observed directly, so the stimulus lets anchor windows expire back to back. It then reads the growing W from the tick on which rx_enable rises, and confirms the return to the base width after one received packet. The clamp case uses large accuracies with an accumulated miss count. The reply-window edge is reached by placing sync one tick before the timeout.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  typedef enum logic [1:0] {
    WS_IDLE,
    WS_WAIT,
    WS_OPEN,
    WS_HOLD
  } win_state_t;

  localparam int unsigned PPM_SCALE = 1000000;
  localparam int unsigned PPM_ROUND = PPM_SCALE - 1;
endpackage

// File: rtl/rxw_widen.sv
module rxw_widen #(
  parameter int PPM_W     = 10,
  parameter int INTV_W    = 22,
  parameter int MISS_W    = 3,
  parameter int MARGIN_US = 16,
  parameter int LEAD_US   = 500,
  parameter int WID_W     = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PPM_W-1:0]  peer_ppm,
  input  logic [PPM_W-1:0]  local_ppm,
  input  logic [INTV_W-1:0] interval_us,
  input  logic [MISS_W-1:0] miss_cnt,
  output logic [WID_W-1:0]  widen_us
);
  import rxw_pkg::*;

  localparam int EL_W = INTV_W + MISS_W + 1;
  localparam int PR_W = PPM_W + EL_W + 2;

  logic [EL_W-1:0]  elapsed;
  logic [PPM_W-1:0] side_ppm [2];
  logic [PR_W-1:0]  side_us  [2];
  logic [PR_W-1:0]  total;

  // drift window grows with the number of anchors since the last good one
  assign elapsed     = EL_W'(interval_us) * (EL_W'(miss_cnt) + EL_W'(1));
  assign side_ppm[0] = peer_ppm;
  assign side_ppm[1] = local_ppm;

  for (genvar s = 0; s < 2; s++) begin : g_side
    assign side_us[s] = (PR_W'(side_ppm[s]) * PR_W'(elapsed) + PR_W'(PPM_ROUND))
                        / PR_W'(PPM_SCALE);
  end

  assign total = side_us[0] + side_us[1] + PR_W'(MARGIN_US);

  always_ff @(posedge clk) begin
    if (!rst_n) widen_us <= WID_W'(MARGIN_US);
    else if (total > PR_W'(LEAD_US)) widen_us <= WID_W'(LEAD_US);
    else widen_us <= WID_W'(total);
  end

  assert_widen_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (widen_us <= WID_W'(LEAD_US)) && (widen_us >= WID_W'(MARGIN_US)));
endmodule

// File: rtl/rxw_window.sv
module rxw_window #(
  parameter int IFS_US     = 150,
  parameter int IFS_JIT_US = 2,
  parameter int SYNC_US    = 40,
  parameter int LEAD_US    = 500,
  parameter int MISS_W     = 3,
  parameter int WID_W      = 9,
  parameter int CNT_W      = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic              tx_end,
  input  logic              anchor,
  input  logic              sync_found,
  input  logic              pkt_end,
  input  logic [WID_W-1:0]  widen_us,
  output logic              rx_on,
  output logic              missed,
  output logic              pkt_done,
  output logic [MISS_W-1:0] miss_cnt
);
  import rxw_pkg::*;

  localparam logic [CNT_W-1:0] IFS_OPEN  = CNT_W'(IFS_US - IFS_JIT_US);
  localparam logic [CNT_W-1:0] IFS_CLOSE = CNT_W'(IFS_US + SYNC_US + IFS_JIT_US);
  localparam logic [MISS_W-1:0] MISS_MAX = {MISS_W{1'b1}};

  win_state_t       state;
  logic [CNT_W-1:0] cnt, cnt_nx, open_at, close_at;

  assign cnt_nx   = cnt + CNT_W'(1);
  assign rx_on    = (state == WS_OPEN) || (state == WS_HOLD);
  assign pkt_done = (state == WS_HOLD) && pkt_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= WS_IDLE;
      cnt      <= '0;
      open_at  <= '0;
      close_at <= '0;
      missed   <= 1'b0;
      miss_cnt <= '0;
    end else begin
      missed <= 1'b0;
      unique case (state)
        WS_IDLE: begin
          if (tx_end) begin
            cnt      <= '0;
            open_at  <= IFS_OPEN;
            close_at <= IFS_CLOSE;
            state    <= WS_WAIT;
          end else if (anchor) begin
            cnt      <= '0;
            open_at  <= CNT_W'(LEAD_US) - CNT_W'(widen_us);
            close_at <= CNT_W'(LEAD_US + SYNC_US) + CNT_W'(widen_us);
            state    <= (widen_us == WID_W'(LEAD_US)) ? WS_OPEN : WS_WAIT;
          end
        end
        WS_WAIT: begin
          if (us_tick) begin
            cnt <= cnt_nx;
            if (cnt_nx == open_at) state <= WS_OPEN;
          end
        end
        WS_OPEN: begin
          if (sync_found) begin
            state <= WS_HOLD;
          end else if (us_tick) begin
            cnt <= cnt_nx;
            if (cnt_nx == close_at) begin
              state  <= WS_IDLE;
              missed <= 1'b1;
              if (miss_cnt != MISS_MAX) miss_cnt <= miss_cnt + MISS_W'(1);
            end
          end
        end
        WS_HOLD: begin
          if (pkt_end) begin
            state    <= WS_IDLE;
            miss_cnt <= '0;
          end
        end
        default: state <= WS_IDLE;
      endcase
    end
  end

  assert_miss_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    missed |-> $fell(rx_on));
  assert_miss_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    missed |=> !missed);
  assert_hold_to_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rx_on) && !missed) |-> $past(pkt_end));
  assert_miss_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> (miss_cnt == '0));
endmodule

// File: rtl/rxw_txsched.sv
module rxw_txsched #(
  parameter int IFS_US = 150,
  parameter int CNT_W  = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic start,
  output logic tx_start
);
  logic             busy;
  logic [CNT_W-1:0] cnt, cnt_nx;

  assign cnt_nx = cnt + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      tx_start <= 1'b0;
    end else begin
      tx_start <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy && us_tick) begin
        cnt <= cnt_nx;
        if (cnt_nx == CNT_W'(IFS_US)) begin
          tx_start <= 1'b1;
          busy     <= 1'b0;
        end
      end
    end
  end

  assert_tx_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);
  assert_tx_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> ($past(busy) && !busy));
endmodule

// File: rtl/rxw_timer.sv
module rxw_timer #(
  parameter int IFS_US         = 150,
  parameter int IFS_JIT_US     = 2,
  parameter int SYNC_US        = 40,
  parameter int MARGIN_US      = 16,
  parameter int ANCHOR_LEAD_US = 500,
  parameter int PPM_W          = 10,
  parameter int INTV_W         = 22,
  parameter int MISS_W         = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic              tx_end,
  input  logic              anchor,
  input  logic              sync_found,
  input  logic              pkt_end,
  input  logic [PPM_W-1:0]  peer_ppm,
  input  logic [PPM_W-1:0]  local_ppm,
  input  logic [INTV_W-1:0] interval_us,
  output logic              rx_enable,
  output logic              tx_start,
  output logic              missed
);
  localparam int WID_W = $clog2(ANCHOR_LEAD_US + 1);
  localparam int CNT_W = $clog2(2 * ANCHOR_LEAD_US + SYNC_US + IFS_US + 2);

  logic [WID_W-1:0]  widen_us;
  logic [MISS_W-1:0] miss_cnt;
  logic              pkt_done;

  rxw_widen #(
    .PPM_W(PPM_W), .INTV_W(INTV_W), .MISS_W(MISS_W),
    .MARGIN_US(MARGIN_US), .LEAD_US(ANCHOR_LEAD_US), .WID_W(WID_W)
  ) u_widen (
    .clk(clk), .rst_n(rst_n), .peer_ppm(peer_ppm), .local_ppm(local_ppm),
    .interval_us(interval_us), .miss_cnt(miss_cnt), .widen_us(widen_us)
  );

  rxw_window #(
    .IFS_US(IFS_US), .IFS_JIT_US(IFS_JIT_US), .SYNC_US(SYNC_US),
    .LEAD_US(ANCHOR_LEAD_US), .MISS_W(MISS_W), .WID_W(WID_W), .CNT_W(CNT_W)
  ) u_window (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .tx_end(tx_end),
    .anchor(anchor), .sync_found(sync_found), .pkt_end(pkt_end),
    .widen_us(widen_us), .rx_on(rx_enable), .missed(missed),
    .pkt_done(pkt_done), .miss_cnt(miss_cnt)
  );

  rxw_txsched #(
    .IFS_US(IFS_US), .CNT_W(CNT_W)
  ) u_txsched (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .start(pkt_done),
    .tx_start(tx_start)
  );
endmodule

// File: tb/tb_rxw_timer.sv
module tb_rxw_timer;
  localparam int LEAD = 500;
  localparam int EV_ON = 0, EV_OFF = 1, EV_TX = 2, EV_MISS = 3;

  typedef struct {
    int     kind;
    longint at;
    string  req;
  } ev_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic us_tick = 1'b0, tx_end = 1'b0, anchor = 1'b0, sync_found = 1'b0, pkt_end = 1'b0;
  logic [9:0]  peer_ppm = '0, local_ppm = '0;
  logic [21:0] interval_us = '0;
  logic rx_enable, tx_start, missed;

  longint tcount = 0;
  int     nchecks = 0, nerrors = 0;
  int     m_model = 0;
  bit     done = 1'b0;
  logic   prv_rx = 1'b0;
  ev_t    q[$];

  always #4 clk = ~clk;

  rxw_timer dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .tx_end(tx_end), .anchor(anchor),
    .sync_found(sync_found), .pkt_end(pkt_end), .peer_ppm(peer_ppm),
    .local_ppm(local_ppm), .interval_us(interval_us), .rx_enable(rx_enable),
    .tx_start(tx_start), .missed(missed)
  );

  function automatic int wexp(int p, int l, int iv, int m);
    longint e, a, b, t;
    e = longint'(iv) * (m + 1);
    a = (p * e + 999999) / 1000000;
    b = (l * e + 999999) / 1000000;
    t = a + b + 16;
    return (t > LEAD) ? LEAD : int'(t);
  endfunction

  task automatic expect_ev(int kind, longint at, string req);
    ev_t e;
    e.kind = kind; e.at = at; e.req = req;
    q.push_back(e);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) us_tick = 1'b1;
      @(posedge clk) tcount++;
      @(negedge clk) us_tick = 1'b0;
    end
  endtask

  task automatic strobe(ref logic sig);
    @(negedge clk) sig = 1'b1;
    @(negedge clk) sig = 1'b0;
  endtask

  task automatic drain(string req);
    repeat (3) @(negedge clk);
    nchecks++;
    if (q.size() != 0) begin
      nerrors++;
      $display("FAIL %s: %0d expected events not seen (expected 0)", req, q.size());
      q.delete();
    end
  endtask

  // scoreboard monitor
  task automatic check_ev(int kind);
    ev_t e;
    nchecks++;
    if (q.size() == 0) begin
      nerrors++;
      $display("FAIL R10: unexpected event kind %0d at tick %0d (expected none)", kind, tcount);
      return;
    end
    e = q.pop_front();
    if (e.kind != kind || e.at != tcount) begin
      nerrors++;
      $display("FAIL %s: event kind %0d at tick %0d (expected kind %0d at tick %0d)",
               e.req, kind, tcount, e.kind, e.at);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_enable && !prv_rx) check_ev(EV_ON);
      if (!rx_enable && prv_rx) check_ev(EV_OFF);
      if (tx_start) check_ev(EV_TX);
      if (missed) check_ev(EV_MISS);
    end
    prv_rx = rx_enable;
  end

  task automatic anchor_miss(string req);
    int w;
    longint b;
    w = wexp(peer_ppm, local_ppm, interval_us, m_model);
    b = tcount;
    expect_ev(EV_ON, b + LEAD - w, req);
    expect_ev(EV_OFF, b + LEAD + 40 + w, "R7");
    expect_ev(EV_MISS, b + LEAD + 40 + w, "R7");
    strobe(anchor);
    ticks(LEAD + 40 + w + 2);
    if (m_model < 7) m_model++;
    drain(req);
  endtask

  initial begin
    longint b;
    int w;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    nchecks++;
    if (rx_enable !== 1'b0 || tx_start !== 1'b0 || missed !== 1'b0) begin
      nerrors++;
      $display("FAIL R1: outputs %b%b%b (expected 000)", rx_enable, tx_start, missed);
    end

    // R2 / R3 / R5: reply window, sync, hold past timeout, reply strobe
    b = tcount;
    expect_ev(EV_ON, b + 148, "R2");
    strobe(tx_end);
    ticks(158);
    strobe(sync_found);
    ticks(100);
    expect_ev(EV_OFF, tcount, "R3");
    expect_ev(EV_TX, tcount + 150, "R5");
    strobe(pkt_end);
    ticks(160);
    drain("R3");

    // R4: reply window with no sync
    b = tcount;
    expect_ev(EV_ON, b + 148, "R2");
    expect_ev(EV_OFF, b + 192, "R4");
    expect_ev(EV_MISS, b + 192, "R4");
    strobe(tx_end);
    ticks(200);
    m_model = 1;
    drain("R4");

    // R4 boundary: sync just before the last tick
    b = tcount;
    expect_ev(EV_ON, b + 148, "R2");
    strobe(tx_end);
    ticks(191);
    strobe(sync_found);
    ticks(5);
    expect_ev(EV_OFF, tcount, "R4");
    expect_ev(EV_TX, tcount + 150, "R5");
    strobe(pkt_end);
    ticks(155);
    m_model = 0;
    drain("R4");

    // R6 / R7 / R8: anchor windows widening after consecutive misses
    peer_ppm = 10'd100; local_ppm = 10'd30; interval_us = 22'd10000;
    repeat (3) @(negedge clk);
    anchor_miss("R6");
    anchor_miss("R8");
    w = wexp(peer_ppm, local_ppm, interval_us, m_model);
    nchecks++;
    if (w != 20) begin
      nerrors++;
      $display("FAIL R8: model widening %0d (expected 20)", w);
    end
    b = tcount;
    expect_ev(EV_ON, b + LEAD - w, "R8");
    strobe(anchor);
    ticks(LEAD - w + 5);
    strobe(sync_found);
    expect_ev(EV_OFF, tcount, "R3");
    expect_ev(EV_TX, tcount + 150, "R5");
    strobe(pkt_end);
    ticks(152);
    m_model = 0;
    drain("R8");
    anchor_miss("R8");

    // R9: clamp to lead
    peer_ppm = 10'd1000; local_ppm = 10'd1000; interval_us = 22'd300000;
    repeat (3) @(negedge clk);
    anchor_miss("R9");

    // R10: ignored stimuli
    b = tcount;
    expect_ev(EV_ON, b + 148, "R10");
    expect_ev(EV_OFF, b + 192, "R10");
    expect_ev(EV_MISS, b + 192, "R10");
    strobe(tx_end);
    ticks(10);
    strobe(sync_found);
    strobe(anchor);
    strobe(pkt_end);
    ticks(140);
    strobe(tx_end);
    ticks(50);
    ticks(120);
    drain("R10");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nchecks, nerrors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerrors++;
      $display("FAIL watchdog: run did not complete (expected completion)");
      $display("CHECKS %0d ERRORS %0d", nchecks, nerrors);
      $finish;
    end
  end
endmodule